// File: doc/BRIEF.md
# Clock Frequency Trim Calculator

This block derives a corrected increment for a free-running time counter. It takes the counter's nominal per-tick increment and a signed frequency offset in parts per million, carried as a fixed-point value with 16 fractional bits. It returns the nominal increment moved by the matching fraction of itself: up for a positive offset and down for a negative one.

The calculation runs over many cycles. The offset magnitude is first limited to a maximum adjustment. A shift-add multiplier then forms the product of the increment and the magnitude. If that product does not fit in the increment width, the magnitude and the divisor of one million are both shifted right by two bits and the product is formed again. The product, shifted right by the 16 fractional bits, then goes through a restoring divider. The quotient is added to or subtracted from the nominal increment.

A single-cycle `start` launches a run. `done` marks completion, and the result stays on its output until the next run completes. Writing the result into the time counter is left to the surrounding logic.

Top module: `freq_trim_calc`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` and `done` are 0 and `trimmed_inc` is 0.
- R2: A `start` seen while `busy` is 0 captures `nominal_inc` and `ppm_offset` and raises `busy` on the next cycle. A `start` seen while `busy` is 1 is dropped and does not cause a second run.
- R3: For a positive offset (bit 63 of `ppm_offset` clear) the result is nominal + floor(floor(nominal × m / 2^16) / d). Here m is the offset magnitude and d is 1,000,000, and both are subject to R5 and R6.
- R4: For a negative offset (bit 63 set, two's complement) the result is nominal − floor(floor(nominal × m / 2^16) / d). The magnitude m is the negated offset.
- R5: An offset magnitude larger than 999,999,999 is replaced by 999,999,999. This includes the most negative input value.
- R6: While nominal × m does not fit in 64 bits, m and d are both shifted right by 2 bits before the product is formed again.
- R7: A zero offset returns the nominal increment unchanged.
- R8: `done` is high for exactly one cycle per accepted `start`, with `busy` low in that cycle. `trimmed_inc` changes only in a `done` cycle and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a calculation (taken only when idle) |
| nominal_inc | input | 64 | Nominal per-tick increment of the time counter |
| ppm_offset | input | 64 | Signed offset in ppm with 16 fractional bits |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle completion pulse |
| trimmed_inc | output | 64 | Adjusted increment, held between completions |

## Verification
The assertions watch the handshake on every cycle: a start taken while idle raises busy, done lasts a single cycle with busy low, and the result never moves outside a done cycle. They also check that the held magnitude never exceeds the clamp and that every divider remainder is below its divisor. Only the directed scenarios can show that the arithmetic is right. These cover offsets of both signs, zero, clamped magnitudes, a product large enough to force the joint shifting, and a second start dropped while busy, each compared with a value the bench computes.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_MUL  = 2'd1,
    TS_DIV  = 2'd2
  } trim_state_t;
endpackage

// File: rtl/trim_mul.sv
module trim_mul #(
  parameter int A_W = 64,
  parameter int B_W = 30,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  output logic           done,
  output logic [P_W-1:0] prod
);
  logic           run_q;
  logic [P_W-1:0] acc_q;
  logic [P_W-1:0] mcand_q;
  logic [B_W-1:0] mplr_q;
  logic           done_q;

  // shift-add: one multiplier bit per cycle, stops once no ones remain
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !run_q) begin
        acc_q   <= '0;
        mcand_q <= P_W'(op_a);
        mplr_q  <= op_b;
        run_q   <= 1'b1;
      end else if (run_q) begin
        if (mplr_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          if (mplr_q[0]) acc_q <= acc_q + mcand_q;
          mcand_q <= mcand_q << 1;
          mplr_q  <= mplr_q >> 1;
        end
      end
    end
  end

  assign done = done_q;
  assign prod = acc_q;

  // R8: completion of the multiplier is a single pulse
  a_r8_mul_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/trim_div.sv
module trim_div #(
  parameter int W = 64,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  logic             run_q;
  logic [W:0]       rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [W:0]       rem_sh;
  logic             fits;

  always_comb begin
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    fits   = rem_sh >= {1'b0, den_q};
  end

  // restoring division, one quotient bit per cycle, MSB first
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !run_q) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CNT_W'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) begin
          rem_q <= rem_sh - {1'b0, den_q};
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

  // R3: a finished division leaves a remainder below the divisor
  a_r3_div_rem_below_den: assert property (@(posedge clk) disable iff (rst)
    (done_q && den_q != '0) |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/freq_trim_calc.sv
module freq_trim_calc #(
  parameter int              INC_W      = 64,
  parameter int              PPM_W      = 64,
  parameter int              FRAC_W     = 16,
  parameter int              SHIFT_STEP = 2,
  parameter longint unsigned MAX_ADJ    = 64'd999_999_999,
  parameter longint unsigned DIV_BASE   = 64'd1_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [INC_W-1:0] nominal_inc,
  input  logic [PPM_W-1:0] ppm_offset,
  output logic             busy,
  output logic             done,
  output logic [INC_W-1:0] trimmed_inc
);
  import trim_pkg::*;

  localparam int               MAG_W    = $clog2(MAX_ADJ + 1);
  localparam int               PROD_W   = INC_W + MAG_W;
  localparam logic [PPM_W-1:0] CLAMP_W  = PPM_W'(MAX_ADJ);
  localparam logic [MAG_W-1:0] MAG_MAX  = MAG_W'(MAX_ADJ);
  localparam logic [INC_W-1:0] DVS_INIT = INC_W'(DIV_BASE);

  trim_state_t      state_q;
  logic [INC_W-1:0] nom_q;
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic [INC_W-1:0] dvs_q;
  logic             mul_go_q;
  logic             div_go_q;
  logic [INC_W-1:0] out_q;
  logic             done_q;

  logic [PPM_W-1:0]  ppm_abs;
  logic [MAG_W-1:0]  mag_in;
  logic              mul_done;
  logic [PROD_W-1:0] mul_prod;
  logic              prod_wide;
  logic [INC_W-1:0]  dividend;
  logic              div_done;
  logic [INC_W-1:0]  div_quo;

  // magnitude of the signed offset, limited to the maximum adjustment
  always_comb begin
    ppm_abs   = ppm_offset[PPM_W-1] ? (~ppm_offset + 1'b1) : ppm_offset;
    mag_in    = (ppm_abs > CLAMP_W) ? MAG_MAX : ppm_abs[MAG_W-1:0];
    prod_wide = |mul_prod[PROD_W-1:INC_W];
    dividend  = mul_prod[INC_W-1:0] >> FRAC_W;
  end

  trim_mul #(.A_W(INC_W), .B_W(MAG_W)) u_mul (
    .clk   (clk),
    .rst   (rst),
    .start (mul_go_q),
    .op_a  (nom_q),
    .op_b  (mag_q),
    .done  (mul_done),
    .prod  (mul_prod)
  );

  trim_div #(.W(INC_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_go_q),
    .num   (dividend),
    .den   (dvs_q),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= TS_IDLE;
      nom_q    <= '0;
      mag_q    <= '0;
      neg_q    <= 1'b0;
      dvs_q    <= '0;
      mul_go_q <= 1'b0;
      div_go_q <= 1'b0;
      out_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      mul_go_q <= 1'b0;
      div_go_q <= 1'b0;
      unique case (state_q)
        TS_IDLE: begin
          if (start) begin
            nom_q    <= nominal_inc;
            mag_q    <= mag_in;
            neg_q    <= ppm_offset[PPM_W-1];
            dvs_q    <= DVS_INIT;
            mul_go_q <= 1'b1;
            state_q  <= TS_MUL;
          end
        end
        TS_MUL: begin
          if (mul_done) begin
            if (prod_wide) begin
              // product too wide: scale magnitude and divisor together
              mag_q    <= mag_q >> SHIFT_STEP;
              dvs_q    <= dvs_q >> SHIFT_STEP;
              mul_go_q <= 1'b1;
            end else begin
              div_go_q <= 1'b1;
              state_q  <= TS_DIV;
            end
          end
        end
        TS_DIV: begin
          if (div_done) begin
            out_q   <= neg_q ? (nom_q - div_quo) : (nom_q + div_quo);
            done_q  <= 1'b1;
            state_q <= TS_IDLE;
          end
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != TS_IDLE);
  assign done        = done_q;
  assign trimmed_inc = out_q;

  // R2: an idle start is taken
  a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8: completion pulse is one cycle wide
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: busy is low when done is reported
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R8: result moves only with done
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(trimmed_inc));
  // R5: working magnitude never above the clamp
  a_r5_mag_clamped: assert property (@(posedge clk) disable iff (rst)
    busy |-> (mag_q <= MAG_MAX));
endmodule

// File: tb/test_freq_trim_calc.sv
module test_freq_trim_calc;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 4000;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] nominal_inc = '0;
  logic [63:0] ppm_offset = '0;
  logic        busy;
  logic        done;
  logic [63:0] trimmed_inc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  freq_trim_calc i_freq_trim_calc (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .nominal_inc (nominal_inc),
    .ppm_offset  (ppm_offset),
    .busy        (busy),
    .done        (done),
    .trimmed_inc (trimmed_inc)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [63:0] model(input logic [63:0] nom, input logic [63:0] ppm);
    logic [63:0]  m;
    logic [63:0]  d;
    logic [127:0] p;
    logic [63:0]  diff;
    m = ppm[63] ? (~ppm + 64'd1) : ppm;
    if (m > 64'd999_999_999) m = 64'd999_999_999;
    d = 64'd1_000_000;
    p = {64'd0, nom} * {64'd0, m};
    while (p[127:64] != 64'd0) begin
      m = m >> 2;
      d = d >> 2;
      p = {64'd0, nom} * {64'd0, m};
    end
    diff = (p[63:0] >> 16) / d;
    return ppm[63] ? (nom - diff) : (nom + diff);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [63:0] nom, input logic [63:0] ppm);
    @(negedge clk);
    nominal_inc = nom;
    ppm_offset  = ppm;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (done !== 1'b1 && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (done !== 1'b1) check({req, " done timeout"}, 64'd0, 64'd1);
  endtask

  task automatic run_one(input string req, input logic [63:0] nom, input logic [63:0] ppm);
    pulse_start(nom, ppm);
    wait_done(req);
    check(req, trimmed_inc, model(nom, ppm));
  endtask

  task automatic t_reset;
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 out", trimmed_inc, 64'd0);
  endtask

  task automatic t_positive;
    run_one("R3 pos 100ppm", 64'h0000_0001_3B13_B13B, 64'd6_553_600);
    run_one("R3 pos small", 64'h0000_0000_0800_0000, 64'd123_456_789);
  endtask

  task automatic t_negative;
    run_one("R4 neg 100ppm", 64'h0000_0001_3B13_B13B, -64'd6_553_600);
    run_one("R4 neg odd", 64'h0000_00FF_0000_1234, -64'd77_777_777);
  endtask

  task automatic t_zero;
    run_one("R7 zero", 64'h0000_0001_3B13_B13B, 64'd0);
    check("R7 unchanged", trimmed_inc, 64'h0000_0001_3B13_B13B);
  endtask

  task automatic t_clamp;
    run_one("R5 clamp pos", 64'h0000_0001_3B13_B13B, 64'h0000_0100_0000_0000);
    run_one("R5 clamp neg", 64'h0000_0001_3B13_B13B, -64'd5_000_000_000);
    run_one("R5 clamp min", 64'h0000_0001_3B13_B13B, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_overflow;
    run_one("R6 shift pos", 64'h0000_0100_0000_0000, 64'd999_999_999);
    run_one("R6 shift neg", 64'h0000_7FFF_FFFF_FFFF, -64'd900_000_000);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] first;
    first = model(64'h0000_0002_0000_0000, 64'd50_000_000);
    pulse_start(64'h0000_0002_0000_0000, 64'd50_000_000);
    repeat (3) @(negedge clk);
    check("R2 busy after start", {63'd0, busy}, 64'd1);
    pulse_start(64'h0000_0000_0000_1000, -64'd1);
    wait_done("R2 ignore");
    check("R2 ignore result", trimmed_inc, first);
    @(negedge clk);
    check("R2 no second run", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_done_hold;
    logic [63:0] held;
    run_one("R8 run", 64'h0000_0001_3B13_B13B, 64'd655_360);
    check("R8 busy low at done", {63'd0, busy}, 64'd0);
    held = trimmed_inc;
    @(negedge clk);
    check("R8 done single", {63'd0, done}, 64'd0);
    repeat (5) @(negedge clk);
    check("R8 hold idle", trimmed_inc, held);
    pulse_start(64'h0000_0004_0000_0000, 64'd1_000_000);
    repeat (4) @(negedge clk);
    check("R8 hold busy", trimmed_inc, held);
    wait_done("R8 next");
    check("R8 next value", trimmed_inc, model(64'h0000_0004_0000_0000, 64'd1_000_000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_positive();
    t_negative();
    t_zero();
    t_clamp();
    t_overflow();
    t_busy_ignore();
    t_done_hold();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule